// File: doc/BRIEF.md
# Serial EEPROM Page Write Controller

This block is the memory side of a two-wire serial slave. A bus front end decodes START, STOP and whole bytes and hands them over as single-cycle event strobes. The controller decides whether each byte is acknowledged and supplies bytes for the master to read. It owns a 256 x 8 nonvolatile array, held in registers, and a 16-byte page buffer.

A write transaction starts with the memory device address. The next byte sets the word pointer, and every byte after that goes into the page buffer at the pointer. The pointer's low four bits advance and wrap inside the page. On STOP, the loaded bytes are committed in a self-timed programming cycle of `WRITE_CYCLES` clocks. While that cycle runs, every byte offered is refused, so a master can poll until the memory answers again. A read transaction returns array bytes starting at the pointer, which advances after each byte.

The state machine has six states:

- **IDLE**: waiting for a START.
- **ADDR**: the first byte after START is expected.
- **WORD**: the word address is expected.
- **LOAD**: page bytes are being filled.
- **READ**: bytes are being returned.
- **PROG**: the write cycle is running.

The transitions are:

- IDLE→ADDR on START.
- ADDR→WORD on a matching address byte with bit 0 = 0.
- ADDR→READ on a matching address byte with bit 0 = 1.
- ADDR→IDLE on any other address byte.
- WORD→LOAD on a byte.
- LOAD→PROG on STOP, when at least one byte is loaded and write control is low.
- LOAD→IDLE on any other STOP.
- ADDR, WORD, LOAD or READ →ADDR on a repeated START.
- ADDR, WORD or READ →IDLE on STOP.
- PROG→IDLE when the timer expires.

Top module: `eep_page_ctrl`

## Requirements
- R1: After reset the block is in IDLE with `busy` low, `resp_valid` low and `tx_valid` low, and no write cycle is pending.
- R2: The first byte after START is acknowledged exactly when bit 7 = 1 and bits 6..1 equal `strap`. Bit 0 = 0 selects a write and bit 0 = 1 selects a read. Any other byte gets `resp_valid` with `resp_ack` = 0. Every response appears in the cycle after its `ev_byte`.
- R3: In a write, the byte after the address is acknowledged and becomes the 8-bit word pointer.
- R4: Each later data byte is acknowledged and stored at the pointer. The pointer's low 4 bits then increment modulo 16 and its upper 4 bits stay unchanged.
- R5: A STOP in LOAD with at least one data byte loaded and `wr_ctrl` low raises `busy` in the next cycle for exactly `WRITE_CYCLES` cycles. When the cycle ends, the loaded bytes are in the array. A STOP that follows only the word address starts no cycle.
- R6: While `busy` is high, every `ev_byte` gets `resp_valid` with `resp_ack` = 0, and START and STOP have no effect.
- R7: If `wr_ctrl` is high at STOP, data bytes are still acknowledged, but `busy` stays low and the array is unchanged.
- R8: In a read, each `ev_rd_req` produces `tx_valid` in the next cycle, with `tx_data` equal to the array byte at the pointer. The pointer then increments and wraps from 255 to 0.
- R9: A repeated START during LOAD discards the loaded bytes without a write cycle, while the pointer is kept.
- R10: A commit changes only the page locations that were loaded. Other bytes of the page keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap | input | 6 | Device strap bits compared with address bits 6..1 |
| wr_ctrl | input | 1 | Write control; high blocks commits |
| ev_start | input | 1 | START or repeated START seen (one cycle) |
| ev_stop | input | 1 | STOP seen (one cycle) |
| ev_byte | input | 1 | A byte from the master is complete (one cycle) |
| rx_byte | input | 8 | Byte value qualified by `ev_byte` |
| ev_rd_req | input | 1 | Front end needs the next byte to send |
| resp_valid | output | 1 | Acknowledge decision valid (one cycle) |
| resp_ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| tx_valid | output | 1 | `tx_data` valid (one cycle) |
| tx_data | output | 8 | Byte to transmit |
| busy | output | 1 | Write cycle running |

## Verification
The bench builds the block with `WRITE_CYCLES` = 40 instead of the millisecond-scale default. This keeps a whole programming cycle short, so polling with refused addresses, a full commit and the exact busy length are all reached within a short run. The strap is set to 6'h2D, so that both a strap mismatch and a cleared bit 7 can be offered as wrong addresses. Pages at 0x00, 0x20, 0x30 and 0xF0 are written first. This makes the in-page wrap, the 255-to-0 read wrap and partial-page commits observable through ordinary reads.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int BYTE_W  = 8;
    localparam int STRAP_W = BYTE_W - 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WORD,
        ST_LOAD,
        ST_READ,
        ST_PROG
    } eep_state_e;
endpackage

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int WRITE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic done
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (go) begin
            remain <= CW'(WRITE_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == CW'(1));
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_W = 4,
    parameter int BYTE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        we,
    input  logic [PAGE_W-1:0]           widx,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [(1<<PAGE_W)-1:0]      mask,
    output logic [BYTE_W-1:0]           data [1<<PAGE_W]
);
    localparam int DEPTH = 1 << PAGE_W;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[g] <= 1'b0;
                data[g] <= '0;
            end else if (clear) begin
                mask[g] <= 1'b0;
            end else if (we && widx == PAGE_W'(g)) begin
                mask[g] <= 1'b1;
                data[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4,
    parameter int BYTE_W = 8
) (
    input  logic                        clk,
    input  logic                        commit,
    input  logic [ADDR_W-PAGE_W-1:0]    page,
    input  logic [(1<<PAGE_W)-1:0]      mask,
    input  logic [BYTE_W-1:0]           wdata [1<<PAGE_W],
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BYTE_W-1:0]           rd_data
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int DEPTH = 1 << PAGE_W;

    logic [BYTE_W-1:0] cells [WORDS];

    // nonvolatile contents: deliberately not cleared by reset
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (mask[i]) begin
                    cells[{page, PAGE_W'(i)}] <= wdata[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= cells[rd_addr];
        end
    end
endmodule

// File: rtl/eep_fsm.sv
module eep_fsm
    import eep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [STRAP_W-1:0]   strap,
    input  logic                 wr_ctrl,
    input  logic                 ev_start,
    input  logic                 ev_stop,
    input  logic                 ev_byte,
    input  logic [BYTE_W-1:0]    rx_byte,
    input  logic                 ev_rd_req,
    input  logic                 page_any,
    input  logic                 prog_done,
    output eep_state_e           state,
    output logic [ADDR_W-1:0]    ptr,
    output logic                 ld_clear,
    output logic                 ld_we,
    output logic                 prog_go,
    output logic                 rd_en,
    output logic                 resp_valid,
    output logic                 resp_ack,
    output logic                 tx_valid
);
    eep_state_e ns;
    logic       addr_match;
    logic       rsp_v_d;
    logic       rsp_a_d;
    logic [ADDR_W-1:0] ptr_page_inc;

    assign addr_match   = rx_byte[BYTE_W-1] && (rx_byte[BYTE_W-2:1] == strap);
    assign ptr_page_inc = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};

    // next-state and strobes
    always_comb begin
        ns       = state;
        ld_clear = 1'b0;
        ld_we    = 1'b0;
        prog_go  = 1'b0;
        rd_en    = 1'b0;
        rsp_v_d  = 1'b0;
        rsp_a_d  = 1'b0;
        unique case (state)
            ST_PROG: begin
                if (ev_byte) rsp_v_d = 1'b1;
                if (prog_done) ns = ST_IDLE;
            end
            ST_IDLE: begin
                if (ev_start) ns = ST_ADDR;
            end
            ST_ADDR: begin
                if (ev_start) begin
                    ns = ST_ADDR;
                end else if (ev_stop) begin
                    ns = ST_IDLE;
                end else if (ev_byte) begin
                    rsp_v_d = 1'b1;
                    rsp_a_d = addr_match;
                    if (!addr_match)     ns = ST_IDLE;
                    else if (rx_byte[0]) ns = ST_READ;
                    else                 ns = ST_WORD;
                end
            end
            ST_WORD: begin
                if (ev_start) begin
                    ns = ST_ADDR;
                end else if (ev_stop) begin
                    ns = ST_IDLE;
                end else if (ev_byte) begin
                    rsp_v_d  = 1'b1;
                    rsp_a_d  = 1'b1;
                    ld_clear = 1'b1;
                    ns       = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (ev_start) begin
                    ns = ST_ADDR;
                end else if (ev_stop) begin
                    if (page_any && !wr_ctrl) begin
                        prog_go = 1'b1;
                        ns      = ST_PROG;
                    end else begin
                        ns = ST_IDLE;
                    end
                end else if (ev_byte) begin
                    rsp_v_d = 1'b1;
                    rsp_a_d = 1'b1;
                    ld_we   = 1'b1;
                end
            end
            ST_READ: begin
                if (ev_start) begin
                    ns = ST_ADDR;
                end else if (ev_stop) begin
                    ns = ST_IDLE;
                end else if (ev_rd_req) begin
                    rd_en = 1'b1;
                end
            end
            default: ns = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= ns;
    end

    // registered outputs and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr        <= '0;
            resp_valid <= 1'b0;
            resp_ack   <= 1'b0;
            tx_valid   <= 1'b0;
        end else begin
            resp_valid <= rsp_v_d;
            resp_ack   <= rsp_a_d;
            tx_valid   <= rd_en;
            if (ld_clear)   ptr <= rx_byte;
            else if (ld_we) ptr <= ptr_page_inc;
            else if (rd_en) ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int PAGE_W       = 4,
    parameter int WRITE_CYCLES = 1_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [5:0]         strap,
    input  logic               wr_ctrl,
    input  logic               ev_start,
    input  logic               ev_stop,
    input  logic               ev_byte,
    input  logic [7:0]         rx_byte,
    input  logic               ev_rd_req,
    output logic               resp_valid,
    output logic               resp_ack,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic               busy
);
    localparam int DEPTH = 1 << PAGE_W;

    eep_state_e        state;
    logic [ADDR_W-1:0] ptr;
    logic              ld_clear;
    logic              ld_we;
    logic              prog_go;
    logic              prog_done;
    logic              rd_en;
    logic [DEPTH-1:0]  mask;
    logic [7:0]        pdata [DEPTH];

    eep_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap      (strap),
        .wr_ctrl    (wr_ctrl),
        .ev_start   (ev_start),
        .ev_stop    (ev_stop),
        .ev_byte    (ev_byte),
        .rx_byte    (rx_byte),
        .ev_rd_req  (ev_rd_req),
        .page_any   (|mask),
        .prog_done  (prog_done),
        .state      (state),
        .ptr        (ptr),
        .ld_clear   (ld_clear),
        .ld_we      (ld_we),
        .prog_go    (prog_go),
        .rd_en      (rd_en),
        .resp_valid (resp_valid),
        .resp_ack   (resp_ack),
        .tx_valid   (tx_valid)
    );

    eep_page_buf #(.PAGE_W(PAGE_W), .BYTE_W(8)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ld_clear),
        .we    (ld_we),
        .widx  (ptr[PAGE_W-1:0]),
        .wdata (rx_byte),
        .mask  (mask),
        .data  (pdata)
    );

    eep_prog_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (prog_go),
        .done  (prog_done)
    );

    eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BYTE_W(8)) u_array (
        .clk     (clk),
        .commit  (prog_done && state == ST_PROG),
        .page    (ptr[ADDR_W-1:PAGE_W]),
        .mask    (mask),
        .wdata   (pdata),
        .rd_en   (rd_en),
        .rd_addr (ptr),
        .rd_data (tx_data)
    );

    assign busy = (state == ST_PROG);
endmodule

// File: rtl/eep_page_ctrl_chk.sv
module eep_page_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_ctrl,
    input logic       ev_stop,
    input logic       ev_byte,
    input logic       ev_rd_req,
    input logic       resp_valid,
    input logic       resp_ack,
    input logic       tx_valid,
    input logic       busy
);
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy && !resp_valid && !tx_valid);

    p_resp_follows_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(ev_byte));

    p_busy_starts_on_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ev_stop));

    p_nack_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ev_byte |=> resp_valid && !resp_ack);

    p_wc_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && ev_stop && wr_ctrl |=> !busy);

    p_tx_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(ev_rd_req));
endmodule

bind eep_page_ctrl eep_page_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .ev_stop    (ev_stop),
    .ev_byte    (ev_byte),
    .ev_rd_req  (ev_rd_req),
    .resp_valid (resp_valid),
    .resp_ack   (resp_ack),
    .tx_valid   (tx_valid),
    .busy       (busy)
);

// File: tb/eep_page_ctrl_test.sv
`timescale 1ns/1ps
module eep_page_ctrl_test;
    localparam int WC = 40;
    localparam logic [5:0] STRAP = 6'h2D;
    localparam logic [7:0] AW = {1'b1, STRAP, 1'b0};
    localparam logic [7:0] AR = {1'b1, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_ctrl = 1'b0;
    logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_rd_req = 0;
    logic [7:0] rx_byte = '0;
    logic resp_valid, resp_ack, tx_valid, busy;
    logic [7:0] tx_data;

    always #2.5 clk = ~clk;

    eep_page_ctrl #(.WRITE_CYCLES(WC)) uut (
        .clk(clk), .rst_n(rst_n), .strap(STRAP), .wr_ctrl(wr_ctrl),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte),
        .rx_byte(rx_byte), .ev_rd_req(ev_rd_req),
        .resp_valid(resp_valid), .resp_ack(resp_ack),
        .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy)
    );

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // behavioural reference: 0 idle,1 addr,2 word,3 load,4 read,5 prog
    int mem [256];
    int pend [int];
    int mode = 0, ptr = 0, cnt = 0;
    int e_rv = 0, e_ack = 0, e_tv = 0, e_td = -1, e_busy = 0;

    initial for (int i = 0; i < 256; i++) mem[i] = -1;

    always @(posedge clk) begin
        e_rv = 0; e_ack = 0; e_tv = 0;
        if (!rst_n) begin
            mode = 0; cnt = 0; pend.delete();
        end else if (mode == 5) begin
            if (ev_byte) begin e_rv = 1; e_ack = 0; end
            cnt--;
            if (cnt == 0) begin
                foreach (pend[k]) mem[(ptr & 8'hF0) | k] = pend[k];
                mode = 0;
            end
        end else if (ev_start) begin
            if (mode != 0 || 1) mode = 1;
        end else if (ev_stop) begin
            if (mode == 3 && pend.num() > 0 && !wr_ctrl) begin mode = 5; cnt = WC; end
            else mode = 0;
        end else if (ev_byte) begin
            if (mode == 1) begin
                e_rv = 1;
                e_ack = (rx_byte[7:1] == {1'b1, STRAP});
                mode = !e_ack ? 0 : (rx_byte[0] ? 4 : 2);
            end else if (mode == 2) begin
                e_rv = 1; e_ack = 1; ptr = rx_byte; pend.delete(); mode = 3;
            end else if (mode == 3) begin
                e_rv = 1; e_ack = 1; pend[ptr & 15] = rx_byte;
                ptr = (ptr & 8'hF0) | ((ptr + 1) & 15);
            end
        end else if (ev_rd_req && mode == 4) begin
            e_tv = 1; e_td = mem[ptr]; ptr = (ptr + 1) % 256;
        end
        e_busy = (mode == 5);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk(e_busy ? "R5" : "R5", busy, e_busy);
            chk(e_busy || e_rv && !e_ack ? "R6/R2" : cur_req, resp_valid, e_rv);
            if (e_rv) chk(cur_req, resp_ack, e_ack);
            chk("R8", tx_valid, e_tv);
            if (e_tv && e_td >= 0) chk(cur_req, tx_data, e_td);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic pulse_start();
        @(negedge clk); ev_start = 1; @(negedge clk); ev_start = 0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); ev_stop = 1; @(negedge clk); ev_stop = 0;
    endtask
    task automatic send(input logic [7:0] b);
        @(negedge clk); ev_byte = 1; rx_byte = b; @(negedge clk); ev_byte = 0;
    endtask
    task automatic rdreq();
        @(negedge clk); ev_rd_req = 1; @(negedge clk); ev_rd_req = 0;
    endtask
    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin @(negedge clk); n++; end
        idle(2);
    endtask
    task automatic write_seq(input logic [7:0] wa, input int n, input int seed);
        pulse_start(); send(AW); send(wa);
        for (int i = 0; i < n; i++) send(8'(seed + i * 7));
        pulse_stop();
    endtask
    task automatic read_seq(input logic [7:0] wa, input int n);
        pulse_start(); send(AW); send(wa); pulse_start(); send(AR);
        for (int i = 0; i < n; i++) rdreq();
        pulse_stop();
    endtask

    int bcount;

    initial begin
        idle(3);
        cur_req = "R1";
        chk("R1", busy, 0); chk("R1", resp_valid, 0); chk("R1", tx_valid, 0);
        rst_n = 1; idle(2);

        cur_req = "R2"; // wrong strap and bit 7 clear both refused
        pulse_start(); send({1'b1, 6'h2C, 1'b0}); pulse_stop();
        pulse_start(); send({1'b0, STRAP, 1'b0}); pulse_stop();

        cur_req = "R3"; // full pages, then R5 busy length and R6 polling
        write_seq(8'h20, 16, 8'h11);
        bcount = 0;
        idle(1);
        cur_req = "R6";
        pulse_start(); send(AW); pulse_stop();
        while (busy) begin @(negedge clk); bcount++; end
        chk("R5", bcount + 7, WC);
        idle(2);
        cur_req = "R5";
        write_seq(8'h30, 16, 8'h40); wait_idle();
        write_seq(8'h00, 16, 8'h80); wait_idle();
        write_seq(8'hF0, 16, 8'hC3); wait_idle();

        cur_req = "R4"; // wrap inside page 0x30
        write_seq(8'h3E, 4, 8'h05); wait_idle();
        read_seq(8'h30, 16);

        cur_req = "R10"; // partial page keeps old bytes
        write_seq(8'h24, 2, 8'h99); wait_idle();
        read_seq(8'h20, 16);

        cur_req = "R7";
        wr_ctrl = 1;
        write_seq(8'h20, 3, 8'h55); idle(3);
        chk("R7", busy, 0);
        wr_ctrl = 0;
        read_seq(8'h20, 4);

        cur_req = "R5"; // word address only: no cycle
        pulse_start(); send(AW); send(8'h00); pulse_stop(); idle(2);
        chk("R5", busy, 0);

        cur_req = "R9"; // repeated start discards page, read from kept pointer
        pulse_start(); send(AW); send(8'h08); send(8'hEE); send(8'hEF);
        pulse_start(); send(AR); rdreq(); rdreq(); pulse_stop(); idle(2);
        chk("R9", busy, 0);

        cur_req = "R8"; // read wraps 255 -> 0
        read_seq(8'hFE, 5);
        idle(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule